// File: doc/BRIEF.md
# Resource-Aware Work-Group Dispatcher

This block feeds work-groups ("thread blocks") of one kernel onto a single multiprocessor. Software loads a kernel configuration giving the per-block need for register-file entries, shared-memory bytes and warp slots, plus the number of blocks in the kernel. The dispatcher then issues blocks one at a time in ascending ID order. Each issue carries the block ID, the residency slot it occupies and the base offsets of its private register and shared-memory partitions.

Admission is static and run-to-completion. A block is issued only when its register, shared-memory and warp needs, and one residency slot, all fit together in what remains. A resident block keeps its partitions until the multiprocessor reports it finished on the completion input. That report frees the block's resources at once, and the next pending block can take the freed slot in the same cycle, while the other resident blocks are still running. Because every block of a kernel has the same demand, partitions are equal-sized and indexed by slot.

Top module: `blk_dispatch`

## Requirements
- R1: A block is issued only when its register, shared-memory and warp needs all fit in the remaining capacity together with the needs of the blocks already resident. The number resident never exceeds the minimum over the pools of floor(total / need), where a zero need does not limit. Every issued partition satisfies base + need <= pool total.
- R2: No more than NUM_SLOTS (8 by default) blocks are resident at once, even when every resource need is zero.
- R3: Block IDs are issued as 0, 1, 2, … in ascending order, with at most one issue per clock.
- R4: An issue takes the lowest-numbered free slot. Its register base is slot × register need, and its shared-memory base is slot × shared-memory need.
- R5: A completion (done_valid with the slot index in done_slot) frees that slot's resources before the issue decision of the same cycle, so a pending block can be issued into that slot at the same clock edge.
- R6: A completion naming a slot that holds no resident block has no effect.
- R7: kernel_done rises at the clock edge that accepts the last block's completion and stays high until the next accepted load. A kernel with zero blocks raises kernel_done at the load edge. No issue happens while kernel_done is high.
- R8: If any need exceeds its pool total, the load sets cfg_error and no block is issued. cfg_error stays high until the next accepted load.
- R9: A cfg_load pulse is ignored while a kernel is still in progress.
- R10: After reset, launch_valid, kernel_done and cfg_error are 0.
- R11: launch_valid and its fields are registered. They appear in the cycle after the clock edge at which the issue was decided, and for one cycle per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load a kernel configuration (accepted only when idle) |
| cfg_reg_need | input | REG_W | Register-file entries per block |
| cfg_smem_need | input | SMEM_W | Shared-memory bytes per block |
| cfg_warp_need | input | WARP_W | Warp slots per block |
| cfg_num_blocks | input | ID_W | Blocks in the kernel |
| done_valid | input | 1 | A resident block has finished |
| done_slot | input | SLOT_W | Slot of the finished block |
| launch_valid | output | 1 | One-cycle issue pulse |
| launch_id | output | ID_W | ID of the issued block |
| launch_slot | output | SLOT_W | Residency slot given to the block |
| launch_reg_base | output | REG_W | Base of the block's register partition |
| launch_smem_base | output | SMEM_W | Base of the block's shared-memory partition |
| kernel_done | output | 1 | Every block has been issued and has completed |
| cfg_error | output | 1 | The last load asked for more than a pool holds |

## Verification
The load is taken at one clock edge. cfg_error and kernel_done for a zero-block kernel are visible right after that edge, and the first issue comes one edge later. The bench keeps a cycle model of occupancy. Before each edge it computes from that model, and from the completion it drives, whether an issue is due at that edge and into which slot. It then compares launch_valid, the slot, the ID, both bases and kernel_done on the following falling edge. A same-cycle backfill is therefore expected on the very edge that accepts the completion. A late or early issue shows up as a mismatch in that one sampled cycle.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;

    parameter int unsigned DEF_SLOTS      = 8;
    parameter int unsigned DEF_REG_TOTAL  = 1024;
    parameter int unsigned DEF_SMEM_TOTAL = 4096;
    parameter int unsigned DEF_WARP_TOTAL = 32;
    parameter int unsigned DEF_ID_W       = 12;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } disp_state_e;

    // width of an index that can address n entries (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/blk_slot_table.sv
module blk_slot_table
    import blk_dispatch_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    localparam int unsigned SLOT_W   = idx_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rel_req,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic              alloc,
    input  logic [SLOT_W-1:0] alloc_slot,
    output logic              rel_ok,
    output logic              free_found,
    output logic [SLOT_W-1:0] free_slot
);

    logic [NUM_SLOTS-1:0] occ;
    logic [NUM_SLOTS-1:0] rel_mask;
    logic [NUM_SLOTS-1:0] occ_after;
    logic [NUM_SLOTS-1:0] occ_next;

    // a release only counts when the named slot is really held
    always_comb begin
        rel_ok = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rel_req && (rel_slot == SLOT_W'(i)) && occ[i]) rel_ok = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign rel_mask[g]  = rel_ok && (rel_slot == SLOT_W'(g));
        assign occ_after[g] = occ[g] && !rel_mask[g];
        assign occ_next[g]  = occ_after[g] || (alloc && (alloc_slot == SLOT_W'(g)));
    end

    // lowest free slot, looking at occupancy after this cycle's release
    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!occ_after[i]) begin
                free_found = 1'b1;
                free_slot  = SLOT_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) occ <= '0;
        else              occ <= occ_next;
    end

endmodule

// File: rtl/blk_pool_counter.sv
module blk_pool_counter #(
    parameter int unsigned W     = 11,
    parameter int unsigned TOTAL = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] need,
    input  logic         take,
    input  logic         give,
    output logic         fits
);

    logic [W-1:0] used;
    logic [W-1:0] after_give;
    logic [W:0]   demand;

    assign after_give = used - (give ? need : '0);
    assign demand     = {1'b0, after_give} + {1'b0, need};
    assign fits       = demand <= (W+1)'(TOTAL);

    always_ff @(posedge clk) begin
        if (rst || clear) used <= '0;
        else              used <= after_give + (take ? need : '0);
    end

endmodule

// File: rtl/blk_dispatch_ctrl.sv
module blk_dispatch_ctrl
    import blk_dispatch_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = DEF_SLOTS,
    parameter int unsigned REG_TOTAL  = DEF_REG_TOTAL,
    parameter int unsigned SMEM_TOTAL = DEF_SMEM_TOTAL,
    parameter int unsigned WARP_TOTAL = DEF_WARP_TOTAL,
    parameter int unsigned ID_W       = DEF_ID_W,
    localparam int unsigned SLOT_W    = idx_width(NUM_SLOTS),
    localparam int unsigned REG_W     = $clog2(REG_TOTAL + 1),
    localparam int unsigned SMEM_W    = $clog2(SMEM_TOTAL + 1),
    localparam int unsigned WARP_W    = $clog2(WARP_TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [REG_W-1:0]  cfg_reg_need,
    input  logic [SMEM_W-1:0] cfg_smem_need,
    input  logic [WARP_W-1:0] cfg_warp_need,
    input  logic [ID_W-1:0]   cfg_num_blocks,
    input  logic              rel_ok,
    input  logic              free_found,
    input  logic [SLOT_W-1:0] free_slot,
    input  logic              fit_reg,
    input  logic              fit_smem,
    input  logic              fit_warp,
    output logic              clear,
    output logic              take,
    output logic [REG_W-1:0]  reg_need,
    output logic [SMEM_W-1:0] smem_need,
    output logic [WARP_W-1:0] warp_need,
    output logic              launch_valid,
    output logic [ID_W-1:0]   launch_id,
    output logic [SLOT_W-1:0] launch_slot,
    output logic [REG_W-1:0]  launch_reg_base,
    output logic [SMEM_W-1:0] launch_smem_base,
    output logic              kernel_done,
    output logic              cfg_error
);

    disp_state_e     state;
    logic [ID_W-1:0] num_q;
    logic [ID_W-1:0] launched;
    logic [ID_W-1:0] completed;
    logic            cfg_bad;
    logic            give;

    assign cfg_bad = (32'(cfg_reg_need)  > REG_TOTAL)  ||
                     (32'(cfg_smem_need) > SMEM_TOTAL) ||
                     (32'(cfg_warp_need) > WARP_TOTAL);

    assign clear = cfg_load && (state == ST_IDLE);
    assign give  = rel_ok && (state == ST_RUN);
    assign take  = (state == ST_RUN) && (launched != num_q) && free_found &&
                   fit_reg && fit_smem && fit_warp;

    always_ff @(posedge clk) begin
        if (rst) begin
            state            <= ST_IDLE;
            num_q            <= '0;
            launched         <= '0;
            completed        <= '0;
            reg_need         <= '0;
            smem_need        <= '0;
            warp_need        <= '0;
            launch_valid     <= 1'b0;
            launch_id        <= '0;
            launch_slot      <= '0;
            launch_reg_base  <= '0;
            launch_smem_base <= '0;
            kernel_done      <= 1'b0;
            cfg_error        <= 1'b0;
        end else begin
            launch_valid <= take;
            if (take) begin
                launch_id        <= launched;
                launch_slot      <= free_slot;
                launch_reg_base  <= REG_W'(32'(free_slot) * 32'(reg_need));
                launch_smem_base <= SMEM_W'(32'(free_slot) * 32'(smem_need));
                launched         <= launched + 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (cfg_load) begin
                        kernel_done <= 1'b0;
                        cfg_error   <= cfg_bad;
                        if (!cfg_bad) begin
                            reg_need  <= cfg_reg_need;
                            smem_need <= cfg_smem_need;
                            warp_need <= cfg_warp_need;
                            num_q     <= cfg_num_blocks;
                            launched  <= '0;
                            completed <= '0;
                            if (cfg_num_blocks == '0) kernel_done <= 1'b1;
                            else                      state       <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (give) begin
                        completed <= completed + 1'b1;
                        if (completed + 1'b1 == num_q) begin
                            kernel_done <= 1'b1;
                            state       <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
    import blk_dispatch_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = DEF_SLOTS,
    parameter int unsigned REG_TOTAL  = DEF_REG_TOTAL,
    parameter int unsigned SMEM_TOTAL = DEF_SMEM_TOTAL,
    parameter int unsigned WARP_TOTAL = DEF_WARP_TOTAL,
    parameter int unsigned ID_W       = DEF_ID_W,
    localparam int unsigned SLOT_W    = idx_width(NUM_SLOTS),
    localparam int unsigned REG_W     = $clog2(REG_TOTAL + 1),
    localparam int unsigned SMEM_W    = $clog2(SMEM_TOTAL + 1),
    localparam int unsigned WARP_W    = $clog2(WARP_TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [REG_W-1:0]  cfg_reg_need,
    input  logic [SMEM_W-1:0] cfg_smem_need,
    input  logic [WARP_W-1:0] cfg_warp_need,
    input  logic [ID_W-1:0]   cfg_num_blocks,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              launch_valid,
    output logic [ID_W-1:0]   launch_id,
    output logic [SLOT_W-1:0] launch_slot,
    output logic [REG_W-1:0]  launch_reg_base,
    output logic [SMEM_W-1:0] launch_smem_base,
    output logic              kernel_done,
    output logic              cfg_error
);

    logic              clear;
    logic              take;
    logic              rel_ok;
    logic              free_found;
    logic [SLOT_W-1:0] free_slot;
    logic              fit_reg;
    logic              fit_smem;
    logic              fit_warp;
    logic [REG_W-1:0]  k_reg_need;
    logic [SMEM_W-1:0] k_smem_need;
    logic [WARP_W-1:0] k_warp_need;
    logic              pool_give;

    assign pool_give = rel_ok;

    blk_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .rel_req    (done_valid),
        .rel_slot   (done_slot),
        .alloc      (take),
        .alloc_slot (free_slot),
        .rel_ok     (rel_ok),
        .free_found (free_found),
        .free_slot  (free_slot)
    );

    blk_pool_counter #(.W(REG_W), .TOTAL(REG_TOTAL)) u_reg_pool (
        .clk (clk), .rst (rst), .clear (clear), .need (k_reg_need),
        .take (take), .give (pool_give), .fits (fit_reg)
    );

    blk_pool_counter #(.W(SMEM_W), .TOTAL(SMEM_TOTAL)) u_smem_pool (
        .clk (clk), .rst (rst), .clear (clear), .need (k_smem_need),
        .take (take), .give (pool_give), .fits (fit_smem)
    );

    blk_pool_counter #(.W(WARP_W), .TOTAL(WARP_TOTAL)) u_warp_pool (
        .clk (clk), .rst (rst), .clear (clear), .need (k_warp_need),
        .take (take), .give (pool_give), .fits (fit_warp)
    );

    blk_dispatch_ctrl #(
        .NUM_SLOTS  (NUM_SLOTS),
        .REG_TOTAL  (REG_TOTAL),
        .SMEM_TOTAL (SMEM_TOTAL),
        .WARP_TOTAL (WARP_TOTAL),
        .ID_W       (ID_W)
    ) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .cfg_load         (cfg_load),
        .cfg_reg_need     (cfg_reg_need),
        .cfg_smem_need    (cfg_smem_need),
        .cfg_warp_need    (cfg_warp_need),
        .cfg_num_blocks   (cfg_num_blocks),
        .rel_ok           (rel_ok),
        .free_found       (free_found),
        .free_slot        (free_slot),
        .fit_reg          (fit_reg),
        .fit_smem         (fit_smem),
        .fit_warp         (fit_warp),
        .clear            (clear),
        .take             (take),
        .reg_need         (k_reg_need),
        .smem_need        (k_smem_need),
        .warp_need        (k_warp_need),
        .launch_valid     (launch_valid),
        .launch_id        (launch_id),
        .launch_slot      (launch_slot),
        .launch_reg_base  (launch_reg_base),
        .launch_smem_base (launch_smem_base),
        .kernel_done      (kernel_done),
        .cfg_error        (cfg_error)
    );

endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
    parameter int unsigned REG_TOTAL  = 1024,
    parameter int unsigned SMEM_TOTAL = 4096,
    parameter int unsigned REG_W      = 11,
    parameter int unsigned SMEM_W     = 13,
    parameter int unsigned ID_W       = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              launch_valid,
    input logic [ID_W-1:0]   launch_id,
    input logic [REG_W-1:0]  launch_reg_base,
    input logic [SMEM_W-1:0] launch_smem_base,
    input logic [REG_W-1:0]  reg_need,
    input logic [SMEM_W-1:0] smem_need,
    input logic              kernel_done,
    input logic              cfg_error
);

    assert_id_step_R3: assert property (@(posedge clk) disable iff (rst)
        (launch_valid && $past(launch_valid)) |-> (launch_id == $past(launch_id) + 1'b1));

    assert_reg_fit_R1: assert property (@(posedge clk) disable iff (rst)
        launch_valid |-> (32'(launch_reg_base) + 32'(reg_need) <= REG_TOTAL));

    assert_smem_fit_R1: assert property (@(posedge clk) disable iff (rst)
        launch_valid |-> (32'(launch_smem_base) + 32'(smem_need) <= SMEM_TOTAL));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> !launch_valid);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        kernel_done |-> !launch_valid);

endmodule

bind blk_dispatch blk_dispatch_chk #(
    .REG_TOTAL  (REG_TOTAL),
    .SMEM_TOTAL (SMEM_TOTAL),
    .REG_W      (REG_W),
    .SMEM_W     (SMEM_W),
    .ID_W       (ID_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .launch_valid     (launch_valid),
    .launch_id        (launch_id),
    .launch_reg_base  (launch_reg_base),
    .launch_smem_base (launch_smem_base),
    .reg_need         (k_reg_need),
    .smem_need        (k_smem_need),
    .kernel_done      (kernel_done),
    .cfg_error        (cfg_error)
);

// File: tb/blk_dispatch_test.sv
module blk_dispatch_test;

    localparam int RT = 1024;
    localparam int ST = 4096;
    localparam int WT = 32;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [10:0] cfg_reg_need = '0;
    logic [12:0] cfg_smem_need = '0;
    logic [5:0]  cfg_warp_need = '0;
    logic [11:0] cfg_num_blocks = '0;
    logic        done_valid = 1'b0;
    logic [2:0]  done_slot = '0;
    logic        launch_valid;
    logic [11:0] launch_id;
    logic [2:0]  launch_slot;
    logic [10:0] launch_reg_base;
    logic [12:0] launch_smem_base;
    logic        kernel_done;
    logic        cfg_error;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // bench model
    logic [7:0] mocc;
    int  mnum, mlaunched, mcompleted, mcap, mrn, msn;
    bit  mrun, mdone, merr;
    bit  last_l;
    int  last_s;

    always #10 clk = ~clk;   // 50 MHz

    blk_dispatch uut (
        .clk (clk), .rst (rst), .cfg_load (cfg_load),
        .cfg_reg_need (cfg_reg_need), .cfg_smem_need (cfg_smem_need),
        .cfg_warp_need (cfg_warp_need), .cfg_num_blocks (cfg_num_blocks),
        .done_valid (done_valid), .done_slot (done_slot),
        .launch_valid (launch_valid), .launch_id (launch_id),
        .launch_slot (launch_slot), .launch_reg_base (launch_reg_base),
        .launch_smem_base (launch_smem_base), .kernel_done (kernel_done),
        .cfg_error (cfg_error)
    );

    function automatic int lim(input int total, input int need);
        return (need == 0) ? 1000 : total / need;
    endfunction

    function automatic int calc_cap(input int rn, input int sn, input int wn);
        int c = NS;
        if (lim(RT, rn) < c) c = lim(RT, rn);
        if (lim(ST, sn) < c) c = lim(ST, sn);
        if (lim(WT, wn) < c) c = lim(WT, wn);
        return c;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one clock: drive completion, predict the issue at this edge, compare after it
    task automatic step(input bit dv, input int ds, input bit ld);
        logic [7:0] occ2;
        bit rel, exp_l;
        int exp_s, res;
        done_valid = dv;
        done_slot  = 3'(ds);
        cfg_load   = ld;
        rel  = mrun && dv && mocc[ds];
        occ2 = mocc;
        if (rel) occ2[ds] = 1'b0;
        res = $countones(occ2);
        exp_s = 0;
        for (int i = NS - 1; i >= 0; i--) if (!occ2[i]) exp_s = i;
        exp_l = mrun && (mlaunched < mnum) && (res < mcap) && (res < NS);
        @(posedge clk);
        @(negedge clk);
        done_valid = 1'b0;
        cfg_load   = 1'b0;
        chk("R1", "launch_valid", launch_valid, exp_l);
        if (exp_l && launch_valid) begin
            chk("R4", "launch_slot", launch_slot, exp_s);
            chk("R3", "launch_id", launch_id, mlaunched);
            chk("R4", "reg_base", launch_reg_base, exp_s * mrn);
            chk("R4", "smem_base", launch_smem_base, exp_s * msn);
        end
        last_l = launch_valid;
        last_s = launch_slot;
        if (exp_l) begin
            occ2[exp_s] = 1'b1;
            mlaunched++;
        end
        mocc = occ2;
        if (rel) begin
            mcompleted++;
            if (mcompleted == mnum) begin
                mrun  = 0;
                mdone = 1;
            end
        end
        chk("R7", "kernel_done", kernel_done, mdone);
        chk("R8", "cfg_error", cfg_error, merr);
    endtask

    task automatic load(input int rn, input int sn, input int wn, input int num);
        cfg_reg_need   = 11'(rn);
        cfg_smem_need  = 13'(sn);
        cfg_warp_need  = 6'(wn);
        cfg_num_blocks = 12'(num);
        cfg_load   = 1'b1;
        done_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_load = 1'b0;
        merr  = (rn > RT) || (sn > ST) || (wn > WT);
        mdone = 0;
        if (!merr) begin
            mnum = num; mlaunched = 0; mcompleted = 0; mocc = '0;
            mrn = rn; msn = sn; mcap = calc_cap(rn, sn, wn);
            mrun = (num != 0);
            mdone = (num == 0);
        end
        chk("R8", "cfg_error after load", cfg_error, merr);
        chk("R7", "kernel_done after load", kernel_done, mdone);
        chk("R11", "no issue on load edge", launch_valid, 0);
    endtask

    task automatic run_random();
        int guard = 0;
        while (mrun && guard < 4000) begin
            bit dv = ($urandom % 3) != 0;
            int ds = 0;
            if ($urandom % 6 == 0) ds = $urandom % NS;
            else begin
                int st = $urandom % NS;
                for (int k = NS - 1; k >= 0; k--)
                    if (mocc[(st + k) % NS]) ds = (st + k) % NS;
            end
            step(dv, ds, 0);
            guard++;
        end
        chk("R7", "kernel finished", mrun, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary_and_end();
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        mocc = '0; mrun = 0; mdone = 0; merr = 0;
        mnum = 0; mlaunched = 0; mcompleted = 0; mcap = 0; mrn = 0; msn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "launch_valid at reset", launch_valid, 0);
        chk("R10", "kernel_done at reset", kernel_done, 0);
        chk("R10", "cfg_error at reset", cfg_error, 0);

        // register-limited kernel: 4 resident at most
        load(256, 512, 4, 20);
        n = 0;
        for (int i = 0; i < 6; i++) begin step(0, 0, 0); n += last_l; end
        chk("R1", "resident limited by registers", n, 4);
        step(1, 2, 0);
        chk("R5", "same-cycle backfill issue", last_l, 1);
        chk("R5", "backfill slot", last_s, 2);
        step(1, 6, 0);
        chk("R6", "completion of empty slot ignored", last_l, 0);
        step(0, 0, 0);
        chk("R6", "still no issue after ignored completion", last_l, 0);
        run_random();

        // shared-memory limited, with a load attempted mid-run
        load(100, 1500, 2, 15);
        step(0, 0, 0);
        step(0, 0, 0);
        cfg_reg_need = 11'd2000;
        step(0, 0, 1);
        chk("R9", "load ignored while running (no error)", cfg_error, 0);
        chk("R1", "no third resident block", last_l, 0);
        run_random();

        // all needs zero except warps: slot count is the limit
        load(0, 0, 3, 30);
        n = 0;
        for (int i = 0; i < 12; i++) begin step(0, 0, 0); n += last_l; end
        chk("R2", "slot-limited residency", n, 8);
        run_random();

        // oversize configurations
        load(2000, 10, 1, 5);
        chk("R8", "register oversize flagged", cfg_error, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0);
        load(10, 10, 40, 5);
        chk("R8", "warp oversize flagged", cfg_error, 1);
        step(0, 0, 0);

        // zero-block kernel
        load(8, 8, 1, 0);
        chk("R7", "empty kernel done at load", kernel_done, 1);
        step(0, 0, 0);

        // warp-limited and random kernels
        load(10, 10, 12, 7);
        run_random();
        for (int k = 0; k < 4; k++) begin
            load($urandom % 300, $urandom % 2000, $urandom % 10, 1 + $urandom % 25);
            run_random();
        end

        summary_and_end();
    end

endmodule